// File: doc/BRIEF.md
# DRAM Strobe-Ordering Cycle Decoder

This block is the control logic on the device side of an asynchronous dynamic RAM. It watches the active-low row strobe, column strobe and write strobe, and the multiplexed address lines. From the order in which the strobes move, it works out the kind of each row cycle: an ordinary access (read or write), a refresh of an externally addressed row, a refresh driven by the internal row counter (plain, or hidden behind a held column strobe), or entry into a two-bit parallel test mode. It keeps the row counter for internal refresh and the latched test flag. It gives out the selected row, a one-cycle refresh strobe for the array, the cycle class and a single data level.

Every strobe and address input passes through a synchronizer clocked by a fast sampling clock. Edges are detected on the synchronized copies, so each port reacts a fixed number of sampling clocks after a strobe edge. The two bits read from the array come in as an input. In a normal read, column address bit 9 chooses which of the two bits appears on the data level. In test mode that column bit has no effect, and the data level reports whether the two bits agree.

Top module: `dram_cycle_decoder`

## Requirements
- R1: When the row strobe falls with the column strobe high, and the column strobe then falls before the row strobe rises, the cycle is an access. `cyc_type` reads 2 (read) if the write strobe is high at the column edge, or 3 (write) if it is low. An access issues no refresh strobe. While the cycle is still open and the column strobe has not yet fallen, `cyc_type` reads 1. It reads 0 only after reset.
- R2: In a normal read, `dq_valid` rises at the column falling edge and `dq_level` equals `rd_bits[n]`, where n is address bit 9 at that edge. `dq_valid` falls when the column strobe rises.
- R3: In a write cycle `dq_valid` stays low.
- R4: If the row strobe rises without any column falling edge in that cycle, the cycle is a RAS-only refresh. `cyc_type` reads 4, exactly one `refresh_stb` pulse is issued, `row_sel` equals the address captured at the row falling edge, and the internal counter does not change.
- R5: If the column strobe is low and the write strobe is high when the row strobe falls, and the column strobe was not held over from an access, the cycle is a counter refresh. `cyc_type` reads 5, one `refresh_stb` pulse is issued with `row_sel` equal to the counter value, and the address inputs have no effect. The counter then advances by one and wraps from 2047 to 0. It is 0 after reset.
- R6: If the column strobe has stayed low since the column falling edge of an access, and the row strobe is raised and then lowered again, the cycle is a hidden refresh. `cyc_type` reads 6, one `refresh_stb` pulse is issued with the counter row, the counter advances, and `dq_valid` and `dq_level` from the earlier read stay unchanged. The write strobe is not looked at. A hidden refresh leaves the test flag as it is.
- R7: If the column strobe and the write strobe are both low when the row strobe falls, and the column strobe is not held over from an access, the test flag `test_mode` sets and `cyc_type` reads 7. No refresh strobe is issued and the counter does not move. The flag stays set through reads, writes and hidden refreshes.
- R8: In a read while `test_mode` is set, `dq_level` is 1 when `rd_bits[0]` equals `rd_bits[1]` and 0 when they differ, whatever address bit 9 is.
- R9: A RAS-only refresh (R4) or a counter refresh (R5) clears `test_mode`.
- R10: `refresh_stb` is never high for two clock cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ROW_W | Multiplexed row/column address |
| rd_bits | input | 2 | The two bits read internally from the array |
| row_sel | output | ROW_W | Row chosen for the current cycle |
| refresh_stb | output | 1 | One-cycle pulse that refreshes `row_sel` |
| test_mode | output | 1 | Latched parallel-test flag |
| cyc_type | output | 3 | Class of the last row cycle (codes in R1 to R7) |
| dq_valid | output | 1 | Data level is driven |
| dq_level | output | 1 | Read data bit, or the pass/fail level in test mode |

## Verification
A wrong counter value does not show until the next counter or hidden refresh, where `row_sel` comes out off by the error. The bench therefore checks the row on every counter refresh across a full wrap. If the held-column-strobe state is lost, the next row pulse is classified as 5 or 7 instead of 6, and `dq_valid` drops about three sampling clocks after the row edge. A test flag in the wrong state shows on the `dq_level` of the very next read, because the pattern sweep includes unequal bit pairs for which the two modes give different answers.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  typedef enum logic [2:0] {
    CT_IDLE   = 3'd0,
    CT_ACCESS = 3'd1,
    CT_READ   = 3'd2,
    CT_WRITE  = 3'd3,
    CT_ROR    = 3'd4,
    CT_CBR    = 3'd5,
    CT_HIDDEN = 3'd6,
    CT_TEST   = 3'd7
  } cyc_t;

endpackage

// File: rtl/dcd_sync.sv
module dcd_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q <= {stg_q[STAGES-2:0], d};
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/dcd_row_ctr.sv
module dcd_row_ctr #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [ROW_W-1:0] cnt
);

  logic [ROW_W-1:0] cnt_q;
  logic [ROW_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + ROW_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  // R5: one step per counter refresh, wrapping naturally
  a_r5_ctr_step: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (cnt == ROW_W'($past(cnt) + 1'b1)));

  // R4: without a refresh request the counter holds
  a_r4_ctr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt));

endmodule

// File: rtl/dcd_classifier.sv
module dcd_classifier
  import dcd_pkg::*;
#(
  parameter int ROW_W   = 11,
  parameter int COL_SEL = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_fall,
  input  logic             ras_rise,
  input  logic             cas_fall,
  input  logic             cas_rise,
  input  logic             cas_low,
  input  logic             we_low,
  input  logic [ROW_W-1:0] addr_s,
  input  logic [1:0]       bits_s,
  input  logic [ROW_W-1:0] ctr_row,
  output logic             ctr_inc,
  output cyc_t             cyc_type,
  output logic [ROW_W-1:0] row_sel,
  output logic             refresh_stb,
  output logic             test_mode,
  output logic             dq_valid,
  output logic             dq_level
);

  cyc_t             type_q, type_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             stb_q, stb_d;
  logic             tm_q, tm_d;
  logic             held_q, held_d;
  logic             dqv_q, dqv_d;
  logic             dql_q, dql_d;
  logic             read_bit;

  always_comb begin
    read_bit = tm_q ? ~(bits_s[0] ^ bits_s[1]) : bits_s[addr_s[COL_SEL]];
  end

  always_comb begin
    type_d  = type_q;
    row_d   = row_q;
    stb_d   = 1'b0;
    tm_d    = tm_q;
    held_d  = held_q;
    dqv_d   = dqv_q;
    dql_d   = dql_q;
    ctr_inc = 1'b0;
    if (ras_fall) begin
      if (cas_low) begin
        if (held_q) begin
          type_d  = CT_HIDDEN;
          row_d   = ctr_row;
          stb_d   = 1'b1;
          ctr_inc = 1'b1;
        end else if (we_low) begin
          type_d = CT_TEST;
          tm_d   = 1'b1;
        end else begin
          type_d  = CT_CBR;
          row_d   = ctr_row;
          stb_d   = 1'b1;
          ctr_inc = 1'b1;
          tm_d    = 1'b0;
        end
      end else begin
        type_d = CT_ACCESS;
        row_d  = addr_s;
      end
    end else if (ras_rise && (type_q == CT_ACCESS)) begin
      type_d = CT_ROR;
      stb_d  = 1'b1;
      tm_d   = 1'b0;
    end
    if (cas_fall && (type_q == CT_ACCESS) && !ras_rise) begin
      held_d = 1'b1;
      if (we_low) begin
        type_d = CT_WRITE;
        dqv_d  = 1'b0;
      end else begin
        type_d = CT_READ;
        dqv_d  = 1'b1;
        dql_d  = read_bit;
      end
    end
    if (cas_rise) begin
      held_d = 1'b0;
      dqv_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= CT_IDLE;
      row_q  <= '0;
      stb_q  <= 1'b0;
      tm_q   <= 1'b0;
      held_q <= 1'b0;
      dqv_q  <= 1'b0;
      dql_q  <= 1'b0;
    end else begin
      type_q <= type_d;
      row_q  <= row_d;
      stb_q  <= stb_d;
      tm_q   <= tm_d;
      held_q <= held_d;
      dqv_q  <= dqv_d;
      dql_q  <= dql_d;
    end
  end

  assign cyc_type    = type_q;
  assign row_sel     = row_q;
  assign refresh_stb = stb_q;
  assign test_mode   = tm_q;
  assign dq_valid    = dqv_q;
  assign dq_level    = dql_q;

  // R10: refresh strobe lasts a single cycle
  a_r10_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_stb |=> !refresh_stb);

  // R7: the flag only rises on a test entry cycle
  a_r7_tm_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_mode) |-> (cyc_type == CT_TEST));

  // R9: the flag only falls on a RAS-only or plain counter refresh
  a_r9_tm_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_mode) |-> ((cyc_type == CT_ROR) || (cyc_type == CT_CBR)));

  // R3: a write never drives data
  a_r3_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == CT_WRITE) |-> !dq_valid);

  // R1: access classes issue no refresh
  a_r1_access_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc_type == CT_READ) || (cyc_type == CT_WRITE) || (cyc_type == CT_ACCESS))
      |-> !refresh_stb);

endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dcd_pkg::*;
#(
  parameter int ROW_W       = 11,
  parameter int COL_SEL     = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [ROW_W-1:0] addr,
  input  logic [1:0]       rd_bits,
  output logic [ROW_W-1:0] row_sel,
  output logic             refresh_stb,
  output logic             test_mode,
  output logic [2:0]       cyc_type,
  output logic             dq_valid,
  output logic             dq_level
);

  localparam int ADDR_W = ROW_W;
  localparam int DAT_W  = ADDR_W + 2;

  logic [2:0]       ctl_s;
  logic [1:0]       strb_p;
  logic [DAT_W-1:0] dat_s;
  logic             ras_fall, ras_rise, cas_fall, cas_rise;
  logic             ctr_inc;
  logic [ROW_W-1:0] ctr_row;
  cyc_t             cyc_q;

  dcd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_ctl_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({we_n, cas_n, ras_n}),
    .q     (ctl_s)
  );

  dcd_sync #(.W(DAT_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({rd_bits, addr}),
    .q     (dat_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_p <= 2'b11;
    end else begin
      strb_p <= ctl_s[1:0];
    end
  end

  always_comb begin
    ras_fall = strb_p[0] & ~ctl_s[0];
    ras_rise = ~strb_p[0] & ctl_s[0];
    cas_fall = strb_p[1] & ~ctl_s[1];
    cas_rise = ~strb_p[1] & ctl_s[1];
  end

  dcd_row_ctr #(.ROW_W(ROW_W)) u_row_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (ctr_inc),
    .cnt   (ctr_row)
  );

  dcd_classifier #(.ROW_W(ROW_W), .COL_SEL(COL_SEL)) u_classifier (
    .clk         (clk),
    .rst_n       (rst_n),
    .ras_fall    (ras_fall),
    .ras_rise    (ras_rise),
    .cas_fall    (cas_fall),
    .cas_rise    (cas_rise),
    .cas_low     (~ctl_s[1]),
    .we_low      (~ctl_s[2]),
    .addr_s      (dat_s[ADDR_W-1:0]),
    .bits_s      (dat_s[DAT_W-1:ADDR_W]),
    .ctr_row     (ctr_row),
    .ctr_inc     (ctr_inc),
    .cyc_type    (cyc_q),
    .row_sel     (row_sel),
    .refresh_stb (refresh_stb),
    .test_mode   (test_mode),
    .dq_valid    (dq_valid),
    .dq_level    (dq_level)
  );

  assign cyc_type = cyc_q;

  // R4: a RAS-only refresh pulse leaves the counter alone
  a_r4_ror_ctr: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_stb && (cyc_q == CT_ROR)) |-> $stable(ctr_row));

  // R6: hidden refresh keeps the data level steady
  a_r6_hidden_dq: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == CT_HIDDEN && $past(cyc_q) == CT_HIDDEN) |-> $stable(dq_level));

endmodule

// File: tb/dram_cycle_decoder_bench.sv
module dram_cycle_decoder_bench;

  localparam int ROW_W = 11;
  localparam int NROWS = 1 << ROW_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             ras_n, cas_n, we_n;
  logic [ROW_W-1:0] addr;
  logic [1:0]       rd_bits;
  logic [ROW_W-1:0] row_sel;
  logic             refresh_stb, test_mode, dq_valid, dq_level;
  logic [2:0]       cyc_type;

  int total = 0;
  int bad   = 0;
  int stb_cnt = 0;
  logic [ROW_W-1:0] stb_row = '0;
  int exp_ctr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dram_cycle_decoder u_dram_cycle_decoder (
    .clk (clk), .rst_n (rst_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
    .addr (addr), .rd_bits (rd_bits), .row_sel (row_sel),
    .refresh_stb (refresh_stb), .test_mode (test_mode), .cyc_type (cyc_type),
    .dq_valid (dq_valid), .dq_level (dq_level)
  );

  always @(negedge clk) begin
    if (rst_n === 1'b1 && refresh_stb === 1'b1) begin
      stb_cnt = stb_cnt + 1;
      stb_row = row_sel;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic ras_open(input int row);
    addr = ROW_W'(row); settle(); ras_n = 1'b0; settle();
  endtask

  task automatic cas_down(input int col, input bit we, input logic [1:0] bits);
    addr = ROW_W'(col); we_n = we; rd_bits = bits; settle();
    cas_n = 1'b0; settle();
  endtask

  task automatic cas_up();
    cas_n = 1'b1; we_n = 1'b1; settle();
  endtask

  task automatic ras_close();
    ras_n = 1'b1; settle();
  endtask

  task automatic cbr(input bit we, input int junk);
    addr = ROW_W'(junk); cas_n = 1'b0; we_n = we; settle();
    ras_n = 1'b0; settle(); ras_n = 1'b1; settle();
    cas_n = 1'b1; we_n = 1'b1; settle();
  endtask

  task automatic ror(input int row);
    addr = ROW_W'(row); settle(); ras_n = 1'b0; settle();
    addr = ~ROW_W'(row); settle(); ras_n = 1'b1; settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s0;
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    addr = '0; rd_bits = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // reset state
    chk("R1 reset cyc_type", cyc_type, 0);
    chk("R9 reset test_mode", test_mode, 0);
    chk("R2 reset dq_valid", dq_valid, 0);
    chk("R10 reset refresh_stb", refresh_stb, 0);

    // R4: RAS-only refresh
    s0 = stb_cnt;
    ror(11'h5A3);
    chk("R4 ror cyc_type", cyc_type, 4);
    chk("R4 ror one pulse", stb_cnt - s0, 1);
    chk("R4 ror row", stb_row, 11'h5A3);

    // R5: counter refresh, counter untouched by ROR
    s0 = stb_cnt;
    cbr(1'b1, 11'h3FF);
    chk("R5 cbr cyc_type", cyc_type, 5);
    chk("R5 cbr one pulse", stb_cnt - s0, 1);
    chk("R5 cbr row", stb_row, exp_ctr);
    exp_ctr = (exp_ctr + 1) % NROWS;

    // R1/R2: normal read sweep over bit pairs and column bit 9
    for (int ca9 = 0; ca9 < 2; ca9++) begin
      for (int b = 0; b < 4; b++) begin
        s0 = stb_cnt;
        ras_open(100 + b);
        chk("R1 open access", cyc_type, 1);
        cas_down((ca9 << 9) | (b * 5), 1'b1, 2'(b));
        chk("R1 read cyc_type", cyc_type, 2);
        chk("R2 read valid", dq_valid, 1);
        chk("R2 read level", dq_level, (b >> ca9) & 1);
        cas_up();
        chk("R2 valid drops", dq_valid, 0);
        ras_close();
        chk("R1 no refresh", stb_cnt - s0, 0);
      end
    end

    // R3: write
    s0 = stb_cnt;
    ras_open(7);
    cas_down(3, 1'b0, 2'b11);
    chk("R1 write cyc_type", cyc_type, 3);
    chk("R3 write quiet", dq_valid, 0);
    cas_up(); ras_close();
    chk("R1 write no refresh", stb_cnt - s0, 0);

    // R6: hidden refresh after a read
    ras_open(9);
    cas_down(11'h200, 1'b1, 2'b10);
    chk("R2 pre-hidden level", dq_level, 1);
    ras_close();
    s0 = stb_cnt;
    addr = 11'h155; ras_n = 1'b0; settle();
    chk("R6 hidden cyc_type", cyc_type, 6);
    chk("R6 hidden pulse", stb_cnt - s0, 1);
    chk("R6 hidden row", stb_row, exp_ctr);
    chk("R6 hidden dq_valid", dq_valid, 1);
    chk("R6 hidden dq_level", dq_level, 1);
    exp_ctr = (exp_ctr + 1) % NROWS;
    ras_close(); cas_up();

    // R7: test entry
    s0 = stb_cnt;
    cbr(1'b0, 11'h0AA);
    chk("R7 entry flag", test_mode, 1);
    chk("R7 entry cyc_type", cyc_type, 7);
    chk("R7 entry no pulse", stb_cnt - s0, 0);

    // R8: compressed read sweep
    for (int ca9 = 0; ca9 < 2; ca9++) begin
      for (int b = 0; b < 4; b++) begin
        ras_open(20);
        cas_down((ca9 << 9) | 1, 1'b1, 2'(b));
        chk("R8 test level", dq_level, (b == 0 || b == 3) ? 1 : 0);
        chk("R7 flag holds", test_mode, 1);
        cas_up(); ras_close();
      end
    end
    // R7: write and hidden refresh keep the flag
    ras_open(21); cas_down(2, 1'b0, 2'b01); cas_up(); ras_close();
    chk("R7 flag after write", test_mode, 1);
    ras_open(22); cas_down(2, 1'b1, 2'b01); ras_close();
    s0 = stb_cnt;
    ras_n = 1'b0; settle();
    chk("R6 hidden in test row", stb_row, exp_ctr);
    chk("R6 hidden in test pulse", stb_cnt - s0, 1);
    exp_ctr = (exp_ctr + 1) % NROWS;
    ras_close(); cas_up();
    chk("R7 flag after hidden", test_mode, 1);

    // R9: exit through ROR
    ror(33);
    chk("R9 exit by ror", test_mode, 0);
    // R9: exit through counter refresh
    cbr(1'b0, 0);
    chk("R7 re-entry", test_mode, 1);
    s0 = stb_cnt;
    cbr(1'b1, 0);
    chk("R9 exit by cbr", test_mode, 0);
    chk("R5 cbr row after test", stb_row, exp_ctr);
    exp_ctr = (exp_ctr + 1) % NROWS;

    // R5: full wrap, address pins varied and ignored
    for (int i = 0; i < NROWS + 2; i++) begin
      cbr(1'b1, (i * 37) & 11'h7FF);
      chk("R5 wrap row", stb_row, exp_ctr);
      exp_ctr = (exp_ctr + 1) % NROWS;
    end
    s0 = stb_cnt;
    ror(11'h7FF);
    cbr(1'b1, 5);
    chk("R10 pulse count", stb_cnt - s0, 2);
    chk("R4 ctr unchanged by ror", stb_row, exp_ctr);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule